// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Shifter

This block exchanges one byte at a time over a three-wire synchronous link made of a shift clock, a serial data output and a serial data input. A transfer sends the held byte out most significant bit first. At the same time it fills the register with the bits that arrive on the data input. When the transfer ends, the register holds the received byte. The register can also be read and written directly while the block is idle.

As a master, the block makes the shift clock by dividing the system clock by 2, 4 or 8. As a slave, it follows an external shift clock. That clock is passed through a two-stage synchronizer, and only its synchronized edges are used. A phase control sets which edge launches data and which edge samples it. A pin-enable control decides whether the block drives its output pins at all.

A transfer starts with a one-cycle `start` pulse. `busy` stays high for the whole byte. `done` pulses for one cycle at the moment `busy` falls. The data ports are a plain register port, not a stream. There is no back-pressure: requests made while `busy` is high are simply dropped, and `done` is the only completion event.

Top module: `tw_serial_shifter`

## Requirements
- R1: After reset, `busy`, `done`, `sck_out` and `sr_q` are all 0.
- R2: While `busy` is 0, a cycle with `sr_we` high loads `sr_wdata` into the register. The new value shows on `sr_q` after the next clock edge. In default phase, `sdo` then shows bit 7 of `sr_q`.
- R3: In master mode the shift clock period is 2, 4 or 8 clock cycles for `div_sel` equal to 00, 01 or 1x. Each period has a low half followed by a high half of equal length.
- R4: In default phase (`alt_phase`=0), `sdo` presents the transmit byte most significant bit first. It changes only on falling shift-clock edges, so it is stable while the clock is high.
- R5: In default phase, `sdi` is sampled on each rising shift-clock edge. After the transfer, `sr_q` holds the eight sampled bits, the first one received in bit 7.
- R6: In alternate phase (`alt_phase`=1), `sdo` changes on the rising edge and `sdi` is sampled on the falling edge. Bit order and the final contents are the same as in R4 and R5.
- R7: In master mode, `busy` stays high for exactly 8 shift-clock periods after `start`, that is 8×divide cycles. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R8: While `busy` is 1, `sr_we` and `start` have no effect. The received byte and the transfer length are unchanged.
- R9: `sck_out` is 0 whenever `busy` is 0, and always 0 in slave mode.
- R10: `sdo_oe` follows `pin_en`. `sck_oe` is high only when `pin_en` is 1 and `slave_mode` is 0.
- R11: In slave mode, shifting is driven by the synchronized edges of `sck_in`, and `div_sel` has no effect. `busy` stays high until the eighth falling edge of `sck_in`, then `done` pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the master shift clock is divided from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1: follow `sck_in`; 0: generate the shift clock |
| pin_en | input | 1 | Route shift clock and data output onto the pins |
| alt_phase | input | 1 | 0: launch on fall, sample on rise; 1: the reverse |
| div_sel | input | 2 | Master divide: 00 /2, 01 /4, 1x /8 |
| sr_we | input | 1 | Write `sr_wdata` into the register while idle |
| sr_wdata | input | DATA_W | Data for a direct register write |
| start | input | 1 | Begin a transfer while idle |
| sr_q | output | DATA_W | Current register contents |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| sck_in | input | 1 | External shift clock (slave mode) |
| sck_out | output | 1 | Generated shift clock (master mode) |
| sck_oe | output | 1 | Drive enable for the shift clock pin |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for the data output pin |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a 3-bit divide counter and a two-stage synchronizer. With that configuration it is practical to sweep every divide code in both phases in master mode, using several byte patterns, and to measure every shift-clock period and high phase against the selected divide. Slave mode is run with each divide code in both phases, which shows that the divide select has no effect there. The number of bits exchanged is small enough that every transmitted bit and every received bit is compared against values the bench computes itself.

// File: rtl/tws_pkg.sv
package tws_pkg;

  // Master divide codes; both upper codes select the slowest rate
  typedef enum logic [1:0] {
    TWS_DIV2  = 2'b00,
    TWS_DIV4  = 2'b01,
    TWS_DIV8  = 2'b10,
    TWS_DIV8B = 2'b11
  } tws_div_e;

  // Cycles spent in each half of a master shift-clock period
  function automatic int unsigned tws_half_period(input logic [1:0] sel);
    case (sel)
      TWS_DIV2: return 1;
      TWS_DIV4: return 2;
      default:  return 4;
    endcase
  endfunction

endpackage

// File: rtl/tws_clkgen.sv
module tws_clkgen #(
  parameter int CW   = 3,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave_mode,
  input  logic [1:0] div_sel,
  input  logic       busy,
  input  logic       go,
  input  logic       sck_in,
  output logic       rise_ev,
  output logic       fall_ev,
  output logic       sck_m
);
  import tws_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;
  logic [CW-1:0] full_m1;
  logic [SYNC:0] sync_q;
  logic          s_rise, s_fall, m_rise, m_fall, m_run;

  always_comb begin
    half_m1 = CW'(tws_half_period(div_sel) - 1);
    full_m1 = CW'(2 * tws_half_period(div_sel) - 1);
  end

  // External clock: SYNC flops, plus one more flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-1:0], sck_in};
  end

  assign s_rise = sync_q[SYNC-1] & ~sync_q[SYNC];
  assign s_fall = ~sync_q[SYNC-1] & sync_q[SYNC];

  // Internal clock: low half first, then high half
  assign m_run = busy & ~slave_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_m <= 1'b0;
    end else if (go || !m_run) begin
      cnt   <= '0;
      sck_m <= 1'b0;
    end else if (cnt == full_m1) begin
      cnt   <= '0;
      sck_m <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == half_m1) sck_m <= 1'b1;
    end
  end

  assign m_rise = m_run & (cnt == half_m1);
  assign m_fall = m_run & (cnt == full_m1);

  assign rise_ev = slave_mode ? (busy & s_rise) : m_rise;
  assign fall_ev = slave_mode ? (busy & s_fall) : m_fall;

endmodule

// File: rtl/tws_shreg.sv
module tws_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         alt_phase,
  input  logic         sdi,
  output logic [W-1:0] q,
  output logic         sdo
);

  logic hold;   // bit sampled on the rising edge (default phase)
  logic out_q;  // bit launched on the rising edge (alternate phase)

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      hold  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (load)         q <= load_data;
      else if (fall_ev) q <= {q[W-2:0], alt_phase ? sdi : hold};
      if (rise_ev && !alt_phase) hold <= sdi;
      if (!busy || (rise_ev && alt_phase)) out_q <= q[W-1];
    end
  end

  assign sdo = alt_phase ? out_q : q[W-1];

endmodule

// File: rtl/tw_serial_shifter.sv
module tw_serial_shifter #(
  parameter int DATA_W      = 8,
  parameter int DIV_CW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              pin_en,
  input  logic              alt_phase,
  input  logic [1:0]        div_sel,
  input  logic              sr_we,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              start,
  output logic [DATA_W-1:0] sr_q,
  output logic              busy,
  output logic              done,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic          go, load, rise_ev, fall_ev, sck_m;
  logic [BW-1:0] bit_cnt;

  assign go   = start & ~busy;
  assign load = sr_we & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
      end else if (fall_ev) begin
        if (bit_cnt == LAST_BIT) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  tws_clkgen #(.CW(DIV_CW), .SYNC(SYNC_STAGES)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .div_sel    (div_sel),
    .busy       (busy),
    .go         (go),
    .sck_in     (sck_in),
    .rise_ev    (rise_ev),
    .fall_ev    (fall_ev),
    .sck_m      (sck_m)
  );

  tws_shreg #(.W(DATA_W)) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .load      (load),
    .load_data (sr_wdata),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .alt_phase (alt_phase),
    .sdi       (sdi),
    .q         (sr_q),
    .sdo       (sdo)
  );

  assign sck_out = sck_m;
  assign sck_oe  = pin_en & ~slave_mode;
  assign sdo_oe  = pin_en;

endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         sck_out,
  input logic         sck_oe,
  input logic         sdo_oe,
  input logic         pin_en,
  input logic         slave_mode,
  input logic         sr_we,
  input logic         start,
  input logic [W-1:0] sr_wdata,
  input logic [W-1:0] sr_q
);

  // R9
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_out);

  // R9
  sck_slave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !sck_out);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sr_we && !start) |=> (sr_q == $past(sr_wdata)));

  // R10
  slave_no_sck_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !sck_oe);

  // R10
  pins_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> (!sdo_oe && !sck_oe));

endmodule

bind tw_serial_shifter tws_chk #(.W(DATA_W)) u_tws_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .sck_out    (sck_out),
  .sck_oe     (sck_oe),
  .sdo_oe     (sdo_oe),
  .pin_en     (pin_en),
  .slave_mode (slave_mode),
  .sr_we      (sr_we),
  .start      (start),
  .sr_wdata   (sr_wdata),
  .sr_q       (sr_q)
);

// File: tb/tw_serial_shifter_bench.sv
module tw_serial_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave_mode = 1'b0, pin_en = 1'b1, alt_phase = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       sr_we = 1'b0, start = 1'b0, sck_in = 1'b0, sdi = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic [7:0] sr_q;
  logic       busy, done, sck_out, sck_oe, sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;

  tw_serial_shifter u_tw_serial_shifter (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .pin_en(pin_en),
    .alt_phase(alt_phase), .div_sel(div_sel), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .start(start), .sr_q(sr_q), .busy(busy), .done(done), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (done) done_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_byte(input logic [7:0] v);
    @(negedge clk); sr_we = 1'b1; sr_wdata = v;
    @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic run_master(input logic [1:0] dv, input bit ap,
                            input logic [7:0] tx, input logic [7:0] ext, input bit poke);
    int n;
    int k = 0, cyc = 0, bcount = 0, last_rise = -1, rise_t = 0;
    bit prev = 0, per_ok = 1, hi_ok = 1;
    logic [7:0] got = 8'h00;
    n = (dv == 2'b00) ? 2 : (dv == 2'b01) ? 4 : 8;
    slave_mode = 1'b0; alt_phase = ap; div_sel = dv;
    load_byte(tx);
    chk(sr_q == tx, "R2 load", int'(sr_q), int'(tx));
    if (!ap) chk(sdo == tx[7], "R2 msb", int'(sdo), int'(tx[7]));
    sdi = ap ? 1'b0 : ext[7];
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (cyc < 400) begin
      cyc++;
      if (busy) bcount++;
      if (sck_out && !prev) begin
        if (last_rise >= 0 && cyc - last_rise != n) per_ok = 0;
        last_rise = cyc; rise_t = cyc;
        if (k < 8) begin
          if (!ap) got[7-k] = sdo;
          else     sdi = ext[7-k];
        end
      end
      if (!sck_out && prev) begin
        if (cyc - rise_t != n/2) hi_ok = 0;
        if (ap && k < 8) got[7-k] = sdo;
        k++;
        if (!ap && k < 8) sdi = ext[7-k];
      end
      if (poke && k == 3) begin sr_we = 1'b1; sr_wdata = ~tx; start = 1'b1; end
      else begin sr_we = 1'b0; start = 1'b0; end
      prev = sck_out;
      if (!busy) break;
      @(negedge clk);
    end
    sr_we = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R7 done at end", int'(done), 1);
    chk(bcount == 8*n, "R7 busy length", bcount, 8*n);
    chk(per_ok, "R3 period", int'(per_ok), 1);
    chk(hi_ok, "R3 high half", int'(hi_ok), 1);
    chk(k == 8, "R3 edge count", k, 8);
    if (!ap) begin
      chk(got == tx, "R4 sdo order", int'(got), int'(tx));
      chk(sr_q == ext, "R5 received", int'(sr_q), int'(ext));
    end else begin
      chk(got == tx, "R6 sdo order", int'(got), int'(tx));
      chk(sr_q == ext, "R6 received", int'(sr_q), int'(ext));
    end
    if (poke) chk(sr_q == ext && bcount == 8*n, "R8 ignored while busy", int'(sr_q), int'(ext));
    @(negedge clk);
    chk(done == 1'b0, "R7 one-cycle done", int'(done), 0);
    chk(!busy && !sck_out, "R9 idle low", int'({busy, sck_out}), 0);
  endtask

  task automatic run_slave(input logic [1:0] dv, input bit ap,
                           input logic [7:0] tx, input logic [7:0] ext);
    logic [7:0] got = 8'h00;
    int d0;
    bit sck_quiet = 1;
    slave_mode = 1'b1; alt_phase = ap; div_sel = dv; sck_in = 1'b0;
    load_byte(tx);
    d0 = done_seen;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (SLV_HALF) @(negedge clk);
    chk(busy == 1'b1, "R11 waits for external clock", int'(busy), 1);
    for (int k = 0; k < 8; k++) begin
      if (!ap) begin
        sdi = ext[7-k];
        repeat (SLV_HALF) begin @(negedge clk); if (sck_out) sck_quiet = 0; end
        got[7-k] = sdo;
        sck_in = 1'b1;
        repeat (SLV_HALF) begin @(negedge clk); if (sck_out) sck_quiet = 0; end
        sck_in = 1'b0;
      end else begin
        sck_in = 1'b1;
        sdi = ext[7-k];
        repeat (SLV_HALF) begin @(negedge clk); if (sck_out) sck_quiet = 0; end
        got[7-k] = sdo;
        sck_in = 1'b0;
        repeat (SLV_HALF) begin @(negedge clk); if (sck_out) sck_quiet = 0; end
      end
    end
    repeat (SLV_HALF) @(negedge clk);
    chk(busy == 1'b0, "R11 busy clears", int'(busy), 0);
    chk(done_seen == d0 + 1, "R11 single done", done_seen - d0, 1);
    chk(got == tx, "R11 sdo order", int'(got), int'(tx));
    chk(sr_q == ext, "R11 received", int'(sr_q), int'(ext));
    chk(sck_quiet, "R9 no clock in slave", int'(sck_quiet), 1);
    slave_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !sck_out && sr_q == 8'h00, "R1 in reset",
        int'({busy, done, sck_out, sr_q}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !sck_out && sr_q == 8'h00, "R1 after reset",
        int'({busy, done, sck_out, sr_q}), 0);

    // R10 pin enables
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        pin_en = p[0]; slave_mode = s[0];
        @(negedge clk);
        chk(sdo_oe == p[0] && sck_oe == (p[0] && !s[0]), "R10 enables",
            int'({sdo_oe, sck_oe}), int'({p[0], p[0] & ~s[0]}));
      end
    end
    pin_en = 1'b1; slave_mode = 1'b0;

    for (int dv = 0; dv < 4; dv++)
      for (int ap = 0; ap < 2; ap++)
        for (int i = 0; i < 3; i++) begin
          logic [7:0] tx, ext;
          tx  = 8'(8'hA5 + 8'(37 * i) + 8'(dv * 11));
          ext = 8'(~tx ^ 8'(8'h5A + 8'(ap * 3)));
          run_master(2'(dv), ap[0], tx, ext, i == 1);
        end

    for (int dv = 0; dv < 4; dv++)
      for (int ap = 0; ap < 2; ap++)
        run_slave(2'(dv), ap[0], 8'(8'hC3 ^ 8'(dv * 17)), 8'(8'h1E + 8'(ap * 64)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule